// File: doc/BRIEF.md
# Per-Channel Clock Blocking Output Generator

This block drives one gating output per direction (receive and transmit) for a 24-channel T1 frame. Each frame lasts 193 bit times: a single framing bit comes first, then 24 channels of 8 bits each. A downstream serial controller, such as an HDLC or LAPD engine, can use the output to gate its clock. The controller then runs only during the timeslots chosen for fractional or primary-rate service.

Each direction has its own bit-time strobe and its own frame sync. Each direction also has its own bit counter, its own 24-bit channel mask and its own output. A host writes each mask as three bytes over a simple synchronous port and can read the bytes back. A new mask value waits in a pending register. It is copied into the active mask only when a new channel or a framing bit begins, so no channel ever changes level partway through.

Top module: `chan_gate_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, both outputs are low and all six mask bytes read back as 0.
- R2: The receive mask bytes sit at host addresses `RX_BASE`+0, +1 and +2, and the transmit mask bytes sit at `TX_BASE`+0, +1 and +2. In byte k, bit j is the mask bit of channel 8k+j+1, so channel 1 is bit 0 of byte 0 and channel 24 is bit 7 of byte 2. A write with `host_we` high is stored on the clock edge. `host_rdata` shows the stored byte at the current address, combinationally.
- R3: A write to any other address changes no mask byte, and such an address reads as 0.
- R4: A clock edge where `*_bit_en` and `*_fsync` are both high starts the framing bit, and the output is low for that bit. The next bit time is bit 0 of channel 1. The frame sync realigns the counter whenever it arrives, including partway through a frame.
- R5: Channel c occupies bit times 8(c-1)+1 to 8c after the framing bit. During that whole span the output is high if the channel's active mask bit is 1 and low if it is 0.
- R6: With no frame sync, the bit counter wraps from the last bit of channel 24 back to a framing bit, so the frame repeats every 193 bit times.
- R7: Receive and transmit masks, counters and outputs are independent of each other.
- R8: A mask write takes effect at the next channel or framing-bit boundary. The channel in progress keeps its level until it ends.
- R9: The bit position advances only on clock edges where `*_bit_en` is high. The output shows the new position on the clock after that edge and holds it while `*_bit_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write enable |
| host_rdata | output | 8 | Readback of the addressed mask byte |
| rx_bit_en | input | 1 | Receive bit-time strobe |
| rx_fsync | input | 1 | Receive frame sync, marks the framing bit |
| rx_blk | output | 1 | Receive channel gating output |
| tx_bit_en | input | 1 | Transmit bit-time strobe |
| tx_fsync | input | 1 | Transmit frame sync, marks the framing bit |
| tx_blk | output | 1 | Transmit channel gating output |

## Verification
If the bit counter is off by even one position, every channel edge moves. A mask with isolated set channels then shows a wrong level within the first eight bit times after a framing bit. A bad wrap point shows up in the second frame that runs without a sync. If the pending mask is copied into the active mask too early, the level changes in the middle of the channel being written, within one bit time. If the byte-to-channel mapping is wrong, the high span lands on the wrong timeslot in the first frame after the write. The readback also disagrees at once.

// File: rtl/chan_gate_gen.sv
module chan_gate_gen #(
  parameter int ADDR_W  = 8,
  parameter int RX_BASE = 8'h10,
  parameter int TX_BASE = 8'h20,
  parameter int N_CH    = 24,
  parameter int CH_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_we,
  output logic [7:0]        host_rdata,
  input  logic              rx_bit_en,
  input  logic              rx_fsync,
  output logic              rx_blk,
  input  logic              tx_bit_en,
  input  logic              tx_fsync,
  output logic              tx_blk
);
  localparam int NBYTES     = N_CH / 8;
  localparam int FRAME_BITS = N_CH * CH_BITS + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int CH_W       = $clog2(N_CH);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] CHB  = POS_W'(CH_BITS);

  logic [1:0] bit_en, fsync, blk;
  logic [N_CH-1:0]  pend_q [2];
  logic [N_CH-1:0]  act_q  [2];
  logic [POS_W-1:0] pos_q  [2];
  logic [POS_W-1:0] pos_nxt[2];
  logic [1:0]       bound;

  assign bit_en = {tx_bit_en, rx_bit_en};
  assign fsync  = {tx_fsync, rx_fsync};
  assign rx_blk = blk[0];
  assign tx_blk = blk[1];

  function automatic logic hit(int d, int k, logic [ADDR_W-1:0] a);
    return a == ADDR_W'((d == 0 ? RX_BASE : TX_BASE) + k);
  endfunction

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      logic [POS_W-1:0] off_n, off;
      if (fsync[d] || pos_q[d] == LAST) pos_nxt[d] = '0;
      else                              pos_nxt[d] = pos_q[d] + 1'b1;
      off_n    = pos_nxt[d] - 1'b1;
      bound[d] = (pos_nxt[d] == '0) || ((off_n % CHB) == '0);
      off      = pos_q[d] - 1'b1;
      blk[d]   = (pos_q[d] != '0) && act_q[d][CH_W'(off / CHB)];
    end
  end

  always_comb begin
    host_rdata = '0;
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < NBYTES; k++)
        if (hit(d, k, host_addr)) host_rdata = pend_q[d][8*k +: 8];
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        pend_q[d] <= '0;
        act_q[d]  <= '0;
        pos_q[d]  <= '0;
      end else begin
        for (int k = 0; k < NBYTES; k++)
          if (host_we && hit(d, k, host_addr)) pend_q[d][8*k +: 8] <= host_wdata;
        if (bit_en[d]) begin
          pos_q[d] <= pos_nxt[d];
          if (bound[d]) act_q[d] <= pend_q[d];
        end
      end
    end
  end
endmodule

// File: rtl/chan_gate_gen_chk.sv
module chan_gate_gen_chk #(
  parameter int POS_W   = 8,
  parameter int LAST    = 192,
  parameter int CH_BITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             fsync,
  input logic             blk,
  input logic [POS_W-1:0] pos
);
  AST_FRAMING_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> !blk); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(blk)); // R9
  AST_MID_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !fsync && pos != '0 && (int'(pos) % CH_BITS) != 0) |=> $stable(blk)); // R8
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) <= LAST); // R6
endmodule

bind chan_gate_gen chan_gate_gen_chk #(.POS_W(POS_W), .LAST(FRAME_BITS - 1), .CH_BITS(CH_BITS)) u_chk_rx (
  .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .fsync(rx_fsync), .blk(rx_blk), .pos(pos_q[0]));
bind chan_gate_gen chan_gate_gen_chk #(.POS_W(POS_W), .LAST(FRAME_BITS - 1), .CH_BITS(CH_BITS)) u_chk_tx (
  .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .fsync(tx_fsync), .blk(tx_blk), .pos(pos_q[1]));

// File: tb/chan_gate_gen_tb.sv
module chan_gate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RXB = 8'h10, TXB = 8'h20;
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {24'h000000, 24'hFFFFFF},
    {24'hFFFFFF, 24'h000000},
    {24'h555555, 24'hAAAAAA},
    {24'h000001, 24'h800000},
    {24'h0F00F0, 24'h123456},
    {24'hFFFF00, 24'h00FFFF}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
  logic host_we = 0;
  logic rx_bit_en = 0, rx_fsync = 0, rx_blk;
  logic tx_bit_en = 0, tx_fsync = 0, tx_blk;
  int n_chk = 0, n_fail = 0, bpos = 0;
  logic [23:0] rx_m = '0, tx_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_gate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata),
    .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync), .rx_blk(rx_blk),
    .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync), .tx_blk(tx_blk));

  function automatic logic expv(logic [23:0] m, int p);
    return (p == 0) ? 1'b0 : m[(p-1)/8];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bpos=%0d actual=%0h expected=%0h", tag, bpos, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    chk({7'd0, rx_blk}, {7'd0, expv(rx_m, bpos)}, {tag, " rx"});
    chk({7'd0, tx_blk}, {7'd0, expv(tx_m, bpos)}, {tag, " tx"});
  endtask

  task automatic step(input logic fs);
    @(negedge clk);
    rx_bit_en = 1; tx_bit_en = 1; rx_fsync = fs; tx_fsync = fs;
    @(negedge clk);
    rx_bit_en = 0; tx_bit_en = 0; rx_fsync = 0; tx_fsync = 0;
    bpos = fs ? 0 : (bpos == 192 ? 0 : bpos + 1);
  endtask

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a;
    #1 chk(host_rdata, exp, tag);
  endtask

  task automatic write_masks(input logic [23:0] r, input logic [23:0] t);
    for (int k = 0; k < 3; k++) begin
      hw(RXB + 8'(k), r[8*k +: 8]);
      hw(TXB + 8'(k), t[8*k +: 8]);
    end
  endtask

  task automatic read_masks(input string tag);
    for (int k = 0; k < 3; k++) begin
      rd(RXB + 8'(k), rx_m[8*k +: 8], tag);
      rd(TXB + 8'(k), tx_m[8*k +: 8], tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1 during reset");
    @(negedge clk) rst_n = 1;
    chk_out("R1 after reset");
    read_masks("R1 readback");

    // R5 R7 R2: table of mask pairs, one full frame each
    for (int v = 0; v < NV; v++) begin
      write_masks(VEC[v][47:24], VEC[v][23:0]);
      rx_m = VEC[v][47:24];
      tx_m = VEC[v][23:0];
      read_masks("R2 readback");
      step(1);
      chk_out("R4 framing bit");
      for (int i = 0; i < 192; i++) begin
        step(0);
        chk_out("R5 R7 channel level");
      end
    end

    // R6: free-running frame without sync
    for (int i = 0; i < 193; i++) begin
      step(0);
      chk_out("R6 wrap");
    end

    // R9: idle cycles hold the output
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_out("R9 idle hold");
    end

    // R8: mid-channel write
    hw(RXB, 8'h00);
    rx_m[7:0] = 8'h00;
    step(1);
    chk_out("R8 framing");
    while (bpos < 20) begin
      step(0);
      chk_out("R8 before write");
    end
    hw(RXB, 8'h0C);
    while (bpos < 24) begin
      step(0);
      chk_out("R8 channel 3 keeps level");
    end
    rx_m[7:0] = 8'h0C;
    while (bpos < 192) begin
      step(0);
      chk_out("R8 new mask");
    end

    // R4: resync partway through a frame
    step(1);
    while (bpos < 50) step(0);
    step(1);
    chk_out("R4 resync framing low");
    step(0);
    chk({7'd0, rx_blk}, {7'd0, rx_m[0]}, "R4 channel 1 after resync rx");
    chk({7'd0, tx_blk}, {7'd0, tx_m[0]}, "R4 channel 1 after resync tx");

    // R3: unmapped addresses
    hw(8'h00, 8'hFF);
    hw(RXB + 8'd3, 8'hFF);
    hw(TXB + 8'd3, 8'hFF);
    hw(8'hFF, 8'hFF);
    read_masks("R3 masks unchanged");
    rd(RXB + 8'd3, 8'h00, "R3 unmapped reads 0");
    rd(8'h00, 8'h00, "R3 unmapped reads 0");
    step(1);
    for (int i = 0; i < 192; i++) begin
      step(0);
      chk_out("R3 frame unchanged");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule